// File: doc/BRIEF.md
# Linked-Descriptor Block Copy Engine

This block copies blocks of 32-bit words by walking a linked list of transfer descriptors kept in memory. Each descriptor is four consecutive words. The engine reads the descriptor, moves the requested number of words between the two addresses it names, and then either follows the link to the next descriptor or stops, depending on an end flag carried in the link word and on a chain-mode setting.

Software drives the engine through three word registers: a descriptor pointer, a control/status register and a mode register. It loads the head of the chain, picks a direction and options in the mode register, and then sets enable and go together. Completion sets a sticky done bit, which can raise an interrupt. An abort stops the walk at once. It raises no interrupt and is seen only through the enable bit reading back as zero. Memory is reached through a simple word port that is always ready and returns read data one cycle after the request.

Top module: `dchain_dma`

## Requirements
- R1: After reset, busy, desc_done, irq and mem_req are 0, and the pointer, control and mode registers (reg_addr 0, 1, 2) all read as 0.
- R2: A descriptor at byte address P is fetched as four reads, in order, at P, P+4, P+8 and P+12. The four words are: first address, second address, byte count, and link word.
- R3: Mode bit 2 selects the direction. When it is 0, words are read upward from the first address and each is written to the same offset above the second address. When it is 1, data goes from the second address to the first. Each word is one read followed in the next cycle by one write. The low 2 bits of both addresses are ignored.
- R4: Bit 0 of the link word is the end flag. Bits 31:4 of the link word, with zeros below them, give the next descriptor address. With mode bit 0 (chain mode) set, the walk continues until a descriptor carries the end flag. With mode bit 0 clear, it stops after the first descriptor.
- R5: The word count is bits CNTW+1:2 of the byte count. A count of zero makes no data access and moves straight on to the link step.
- R6: Writing the control register with bit 0 (enable) and bit 1 (go) both set while idle raises busy on the next cycle. The first request is then a read at the pointer register. The same write while busy has no effect.
- R7: Each descriptor keeps busy high for 10 + 2*words cycles. At the end of the last descriptor, busy falls and control bit 3 (done) reads 1 in the same cycle. Writing 1 to bit 3 clears done, and a start also clears it.
- R8: irq is high exactly while done is set and mode bit 1 (interrupt enable) is set.
- R9: Writing control bit 2 (abort) while busy makes busy 0 on the next cycle. After that there are no more memory requests, control bit 0 reads 0, done stays 0 and irq stays low.
- R10: Writing control bits 3 and 4 together clears both enable and done.
- R11: desc_done is high for exactly one cycle, the last busy cycle of each descriptor.
- R12: Writes to the pointer or mode register while busy are ignored. The pointer register holds the address of the current descriptor, so it reads back the last descriptor's address after completion. Its low 4 bits always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pointer, 1 control, 2 mode |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| busy | output | 1 | Engine walking a chain |
| desc_done | output | 1 | One-cycle pulse per finished descriptor |
| irq | output | 1 | Done interrupt |

## Verification
The main copy path is run over three chains.
- A three-descriptor chain in chain mode mixes a full-count descriptor, a zero-count descriptor and a count with stray low bits. This separates the link-following, skip and truncation behaviours.
- The same head with chain mode off and the direction reversed shows that the end flag is not the only stop condition and that the two addresses swap roles.
- A long single descriptor gives room to try register writes, a second start and an abort while busy. It shows that each of these either is ignored or halts the walk without a done flag.

At every cycle the bench's behavioural model predicts the request address, the request kind, busy, desc_done and irq. It also predicts the final memory image.

// File: rtl/dchain_dma.sv
module dchain_dma #(
  parameter int CNTW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        busy,
  output logic        desc_done,
  output logic        irq
);
  localparam logic [1:0] A_PTR = 2'd0, A_CTRL = 2'd1, A_MODE = 2'd2;
  localparam logic [CNTW-1:0] ONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_DFETCH, S_DWAIT, S_CHECK, S_XRD, S_XWR, S_NEXT} st_t;
  st_t st;

  logic [27:0]     ptr_q;
  logic [2:0]      mode_q;
  logic            en_q, done_q;
  logic [1:0]      widx;
  logic [29:0]     d_src, d_dst;
  logic [CNTW-1:0] d_words, k;
  logic [27:0]     d_next;
  logic            d_last;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire abort_w = wr_ctrl && reg_wdata[2] && busy;
  wire off_w   = wr_ctrl && reg_wdata[3] && reg_wdata[4];
  wire start_w = wr_ctrl && !busy && reg_wdata[0] && reg_wdata[1] && !off_w;
  wire stop_here = d_last || !mode_q[0];
  wire [29:0] rd_w = mode_q[2] ? d_dst : d_src;
  wire [29:0] wr_w = mode_q[2] ? d_src : d_dst;

  assign busy      = st != S_IDLE;
  assign mem_req   = st == S_DFETCH || st == S_XRD || st == S_XWR;
  assign mem_we    = st == S_XWR;
  assign mem_wdata = mem_rdata;
  assign desc_done = st == S_NEXT;
  assign irq       = done_q && mode_q[1];

  always_comb begin
    case (st)
      S_DFETCH: mem_addr = {ptr_q, widx, 2'b00};
      S_XRD:    mem_addr = {rd_w + 30'(k), 2'b00};
      S_XWR:    mem_addr = {wr_w + 30'(k), 2'b00};
      default:  mem_addr = '0;
    endcase
    case (reg_addr)
      A_PTR:   reg_rdata = {ptr_q, 4'b0000};
      A_CTRL:  reg_rdata = {28'd0, done_q, 2'b00, en_q};
      A_MODE:  reg_rdata = {29'd0, mode_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr_q <= '0; mode_q <= '0; en_q <= 1'b0; done_q <= 1'b0;
      widx <= '0; k <= '0; d_src <= '0; d_dst <= '0; d_words <= '0;
      d_next <= '0; d_last <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_PTR && !busy)  ptr_q  <= reg_wdata[31:4];
      if (reg_wr && reg_addr == A_MODE && !busy) mode_q <= reg_wdata[2:0];
      if (abort_w) begin
        st <= S_IDLE; en_q <= 1'b0;
      end else if (off_w) begin
        st <= S_IDLE; en_q <= 1'b0; done_q <= 1'b0;
      end else begin
        if (wr_ctrl && reg_wdata[3]) done_q <= 1'b0;
        if (wr_ctrl && !busy) en_q <= reg_wdata[0];
        if (start_w) begin
          st <= S_DFETCH; widx <= '0; done_q <= 1'b0;
        end
        case (st)
          S_DFETCH: st <= S_DWAIT;
          S_DWAIT: begin
            case (widx)
              2'd0: d_src   <= mem_rdata[31:2];
              2'd1: d_dst   <= mem_rdata[31:2];
              2'd2: d_words <= mem_rdata[CNTW+1:2];
              default: begin d_next <= mem_rdata[31:4]; d_last <= mem_rdata[0]; end
            endcase
            widx <= widx + 2'd1;
            st <= (widx == 2'd3) ? S_CHECK : S_DFETCH;
          end
          S_CHECK: begin
            k <= '0;
            st <= (d_words == '0) ? S_NEXT : S_XRD;
          end
          S_XRD: st <= S_XWR;
          S_XWR: begin
            if (k == d_words - ONE) st <= S_NEXT;
            else begin k <= k + ONE; st <= S_XRD; end
          end
          S_NEXT: begin
            if (stop_here) begin
              st <= S_IDLE; done_q <= 1'b1;
            end else begin
              ptr_q <= d_next; widx <= '0; st <= S_DFETCH;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r6_start_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (busy && mem_req && !mem_we && mem_addr == {$past(ptr_q), 4'b0000}));
  a_r9_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!busy && !en_q && !mem_req && !irq));
  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(st == S_NEXT) && !busy));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);
  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_req && !mem_we));
  a_r12_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_NEXT) |=> ptr_q == $past(ptr_q));
endmodule

// File: tb/dchain_dma_tb_top.sv
module dchain_dma_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, busy, desc_done, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  dchain_dma dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .desc_done(desc_done), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_mem [0:1023];
  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:2]];
    end

  int vectors = 0, fails = 0, cycles = 0;
  bit chk_on = 0, model_busy = 0, model_done = 0, model_ie = 0;
  int cnt = 0;
  int q_base[$], q_rd[$], q_wr[$], q_w[$];

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
    if (chk_on) begin
      automatic bit e_req = 0, e_we = 0, e_dd = 0;
      automatic logic [31:0] e_addr = 0;
      automatic int L = 0;
      if (model_busy) begin
        L = 10 + 2*q_w[0];
        if (cnt < 8) begin
          if (cnt % 2 == 0) begin e_req = 1; e_addr = q_base[0] + 4*(cnt/2); end
        end else if (cnt >= 9 && cnt < 9 + 2*q_w[0]) begin
          e_req = 1;
          if ((cnt-9) % 2 == 0) e_addr = q_rd[0] + 4*((cnt-9)/2);
          else begin e_we = 1; e_addr = q_wr[0] + 4*((cnt-9)/2); end
        end else if (cnt == L-1) e_dd = 1;
      end
      check("R7", "busy", busy, model_busy);
      check("R9", "mem_req", mem_req, e_req);
      check("R11", "desc_done", desc_done, e_dd);
      check("R8", "irq", irq, model_done && model_ie);
      if (e_req) begin
        check("R3", "mem_we", mem_we, e_we);
        check("R2", "mem_addr", mem_addr, e_addr);
      end
      if (model_busy) begin
        cnt++;
        if (cnt == L) begin
          void'(q_base.pop_front()); void'(q_rd.pop_front());
          void'(q_wr.pop_front()); void'(q_w.pop_front());
          cnt = 0;
          if (q_w.size() == 0) begin model_busy = 0; model_done = 1; end
        end
      end
    end
  end

  task automatic put_desc(input int a, input int s, input int d, input int c, input int n);
    mem[a/4] = s; mem[a/4+1] = d; mem[a/4+2] = c; mem[a/4+3] = n;
    exp_mem[a/4] = s; exp_mem[a/4+1] = d; exp_mem[a/4+2] = c; exp_mem[a/4+3] = n;
  endtask

  task automatic plan_walk(input int head, input bit chain, input bit dir);
    automatic int p = head;
    for (int g = 0; g < 16; g++) begin
      automatic int s = exp_mem[p/4] & ~3, d = exp_mem[p/4+1] & ~3;
      automatic int w = (exp_mem[p/4+2] >> 2) & 16'hFFFF;
      automatic int n = exp_mem[p/4+3];
      automatic int r = dir ? d : s, t = dir ? s : d;
      q_base.push_back(p); q_rd.push_back(r); q_wr.push_back(t); q_w.push_back(w);
      for (int i = 0; i < w; i++) exp_mem[(t/4 + i) % 1024] = exp_mem[(r/4 + i) % 1024];
      if ((n & 1) || !chain) break;
      p = n & ~15;
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(posedge clk);
    #1;
    if (a == 2'd1) begin
      if (v[2] && model_busy) begin
        model_busy = 0; cnt = 0;
        q_base.delete(); q_rd.delete(); q_wr.delete(); q_w.delete();
      end else if (v[3] && v[4]) begin
        model_done = 0;
        if (model_busy) begin
          model_busy = 0; cnt = 0;
          q_base.delete(); q_rd.delete(); q_wr.delete(); q_w.delete();
        end
      end else begin
        if (v[3]) model_done = 0;
        if (v[0] && v[1] && !model_busy) begin
          model_done = 0; model_busy = 1; cnt = 0;
        end
      end
    end
    if (a == 2'd2 && !model_busy) model_ie = v[1];
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    while (model_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_mem(input string tag);
    automatic int bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(tag, "memory words differing", bad, 0);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_on = 1;
    rd_reg(2'd0, v); check("R1", "ptr after reset", v, 0);
    rd_reg(2'd1, v); check("R1", "ctrl after reset", v, 0);
    rd_reg(2'd2, v); check("R1", "mode after reset", v, 0);
    check("R1", "busy after reset", busy, 0);

    // R4 R5 three-descriptor chain, forward, interrupt on
    put_desc(32'h000, 32'h200, 32'h400, 16, 32'h040);
    put_desc(32'h040, 32'h240, 32'h440, 0, 32'h080);
    put_desc(32'h080, 32'h281, 32'h480, 14, 32'h0C1);
    wr_reg(2'd0, 32'h0000_0007);
    rd_reg(2'd0, v); check("R12", "ptr low bits masked", v, 0);
    wr_reg(2'd2, 32'h3);
    plan_walk(0, 1, 0);
    wr_reg(2'd1, 32'h3);
    wait_idle();
    rd_reg(2'd1, v); check("R7", "done and enable", v, 32'h9);
    check("R8", "irq after done", irq, 1);
    rd_reg(2'd0, v); check("R12", "ptr holds last descriptor", v, 32'h080);
    cmp_mem("R4");
    wr_reg(2'd1, 32'h9);
    rd_reg(2'd1, v); check("R7", "done cleared by W1C", v, 32'h1);
    check("R8", "irq after clear", irq, 0);

    // R3 chain off, reversed direction, no interrupt
    wr_reg(2'd0, 32'h000);
    wr_reg(2'd2, 32'h4);
    plan_walk(0, 0, 1);
    wr_reg(2'd1, 32'h3);
    wait_idle();
    cmp_mem("R3");
    rd_reg(2'd1, v); check("R7", "done without chain mode", v, 32'h9);
    check("R8", "irq masked", irq, 0);
    wr_reg(2'd1, 32'h18);
    rd_reg(2'd1, v); check("R10", "engine off", v, 0);

    // R6 R12 R9 long walk, writes while busy, then abort
    put_desc(32'h100, 32'h600, 32'h800, 160, 32'h1);
    wr_reg(2'd0, 32'h100);
    wr_reg(2'd2, 32'h3);
    plan_walk(32'h100, 1, 0);
    wr_reg(2'd1, 32'h3);
    repeat (15) @(negedge clk);
    wr_reg(2'd0, 32'h3C0);
    wr_reg(2'd2, 32'h4);
    wr_reg(2'd1, 32'h3);
    rd_reg(2'd0, v); check("R12", "ptr write while busy", v, 32'h100);
    rd_reg(2'd2, v); check("R12", "mode write while busy", v, 32'h3);
    check("R6", "still busy after second start", busy, 1);
    wr_reg(2'd1, 32'h4);
    rd_reg(2'd1, v); check("R9", "enable cleared by abort", v, 0);
    repeat (20) @(negedge clk);
    check("R9", "irq after abort", irq, 0);

    chk_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule